// File: doc/BRIEF.md
# Frame Timer with Memory Contention Stalls

This block keeps video raster timing for a bitmap display. It runs on the CPU T-state clock. A frame is 312 lines of 224 T-states each, so a frame lasts 69888 T-states. The block keeps a position counter and a line counter. It raises a frame interrupt during the first T-states of each frame and flags when the beam is inside the 256-pixel display window. The display window is lines 64 to 255, positions 0 to 127 of each line.

While the display window is being fetched, the video logic owns the shared display memory and the even I/O ports. On each cycle the CPU presents an access (`req_valid`, `req_io`, `req_addr`). The block decides whether that access is contended and, if so, how many T-states it must be held back. The stall follows a fixed eight-cycle pattern (6,5,4,3,2,1,0,0). This pattern is locked to the frame count and starts one T-state before each display line.

The stall length appears as `stall_len` in the same cycle as the request. A wait state machine then drives `cpu_wait` for exactly that many cycles. The machine has two states:
- `ST_IDLE` accepts requests. Its transition `IDLE->HOLD` is taken on a contended request with a non-zero stall.
- `ST_HOLD` counts the stall down. Its transition `HOLD->IDLE` is taken when the last stall cycle ends.

Top module: `fzt_frame_timer`

## Requirements
- R1: `line_pos` counts 0 to 223 and then wraps to 0. `line_num` advances by one at each wrap and runs 0 to 311 before returning to 0. Both counters are 0 while reset is held.
- R2: `frame_irq` is high exactly while the frame cycle count is 0 to 31. The frame cycle count is `line_num`*224+`line_pos`.
- R3: `disp_active` is high exactly when `line_num` is 64 to 255 and `line_pos` is 0 to 127.
- R4: A memory request is contended when `req_addr[15:14]` is 2'b01. An I/O request (`req_io`=1) is contended when `req_addr[0]` is 0. Any other request gets no stall.
- R5: Let a contended request arrive at frame cycle 14335 + 224*L + p, with L from 0 to 191 and p from 0 to 127. It stalls by 6,5,4,3,2,1,0,0 for p mod 8 = 0 to 7. A request at any other frame cycle, such as the top or bottom border or positions 128 and above, gets a stall of 0.
- R6: `stall_len` shows the stall for the request in the same cycle the request is presented. It is 0 when `req_valid` is low.
- R7: `cpu_wait` goes high in the cycle after an accepted request and stays high for exactly `stall_len` cycles. A zero stall produces no wait.
- R8: A request presented while `cpu_wait` is high is ignored. It shows `stall_len`=0 and does not lengthen the wait.
- R9: Asserting `rst_n` low at any time clears `cpu_wait` and both counters at once. This holds even in the middle of a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU access in this cycle |
| req_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_addr | input | 16 | Access address |
| frame_irq | output | 1 | Frame interrupt request |
| line_num | output | 9 | Current line, 0..311 |
| line_pos | output | 8 | T-state within line, 0..223 |
| disp_active | output | 1 | Beam inside display window |
| stall_len | output | 3 | Stall for the current request |
| cpu_wait | output | 1 | Hold the CPU this cycle |

## Verification
The main function is tried with requests at several phases of the eight-cycle pattern. These include the first cycle of the window, phases 1, 2, 3, 5 and 7, and the last display line. Together they separate a correct phase lock from an off-by-one alignment.

Further requests fall just before the window, in the right border and in the bottom border. These show whether the window edges are placed correctly.

Uncontended memory addresses and odd I/O ports at strong-stall phases separate the address decode from the timing. A request held high through a wait shows whether the machine ignores requests while holding.

// File: rtl/fzt_pkg.sv
package fzt_pkg;
    localparam int LINE_T      = 224;
    localparam int FRAME_LINES = 312;
    localparam int DISP_T      = 128;
    localparam int DISP_LINES  = 192;
    localparam int TOP_LINES   = 64;
    localparam int IRQ_T       = 32;
    localparam int PHASES      = 8;
    localparam int MAX_STALL   = 6;

    localparam int POS_W   = $clog2(LINE_T);
    localparam int LINE_W  = $clog2(FRAME_LINES);
    localparam int STALL_W = $clog2(MAX_STALL + 1);
    localparam int PH_W    = $clog2(PHASES);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } wait_st_e;
endpackage

// File: rtl/fzt_beam.sv
module fzt_beam #(
    parameter int LINE_T      = 224,
    parameter int FRAME_LINES = 312,
    parameter int IRQ_T       = 32,
    parameter int POS_W       = 8,
    parameter int LINE_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [POS_W-1:0]  pos,
    output logic [LINE_W-1:0] line,
    output logic              irq
);
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(LINE_T - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(FRAME_LINES - 1);
    localparam logic [POS_W-1:0]  IRQ_END   = POS_W'(IRQ_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos  <= '0;
            line <= '0;
        end else if (pos == POS_LAST) begin
            pos  <= '0;
            line <= (line == LINE_LAST) ? '0 : line + 1'b1;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // interrupt spans the start of line 0 only
    always_comb irq = (line == '0) && (pos < IRQ_END);
endmodule

// File: rtl/fzt_contend.sv
module fzt_contend #(
    parameter int LINE_T     = 224,
    parameter int DISP_T     = 128,
    parameter int DISP_LINES = 192,
    parameter int TOP_LINES  = 64,
    parameter int PHASES     = 8,
    parameter int MAX_STALL  = 6,
    parameter int POS_W      = 8,
    parameter int LINE_W     = 9,
    parameter int STALL_W    = 3,
    parameter int PH_W       = 3
) (
    input  logic [POS_W-1:0]   pos,
    input  logic [LINE_W-1:0]  line,
    input  logic               req_valid,
    input  logic               req_io,
    input  logic [15:0]        req_addr,
    output logic               disp_active,
    output logic [STALL_W-1:0] delay
);
    localparam logic [LINE_W-1:0] L_FIRST = LINE_W'(TOP_LINES);
    localparam logic [LINE_W-1:0] L_LAST  = LINE_W'(TOP_LINES + DISP_LINES - 1);
    localparam logic [POS_W-1:0]  P_DISP  = POS_W'(DISP_T);
    localparam logic [POS_W-1:0]  P_LAST  = POS_W'(LINE_T - 1);

    logic             in_rows;
    logic             lead_rows;
    logic             in_window;
    logic             hit;
    logic [POS_W-1:0] pos_n;
    logic [PH_W-1:0]  phase;

    // stall for each phase of the repeating pattern, computed per entry
    logic [STALL_W-1:0] pat [PHASES];
    for (genvar g = 0; g < PHASES; g++) begin : g_pat
        if (g < MAX_STALL) begin : g_on
            assign pat[g] = STALL_W'(MAX_STALL - g);
        end else begin : g_off
            assign pat[g] = '0;
        end
    end

    always_comb begin
        in_rows     = (line >= L_FIRST) && (line <= L_LAST);
        lead_rows   = (line >= L_FIRST - 1'b1) && (line <= L_LAST - 1'b1);
        disp_active = in_rows && (pos < P_DISP);
        // the window opens one cycle ahead of each display line
        in_window   = (in_rows && (pos < P_DISP - 1'b1)) ||
                      (lead_rows && (pos == P_LAST));
        pos_n       = pos + 1'b1;
        phase       = pos_n[PH_W-1:0];
        hit         = req_valid &&
                      (req_io ? !req_addr[0] : (req_addr[15:14] == 2'b01));
        delay       = (hit && in_window) ? pat[phase] : '0;
    end
endmodule

// File: rtl/fzt_wait_fsm.sv
module fzt_wait_fsm
    import fzt_pkg::*;
#(
    parameter int STALL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STALL_W-1:0] delay,
    output logic [STALL_W-1:0] stall_len,
    output logic               cpu_wait
);
    wait_st_e           state, state_n;
    logic [STALL_W-1:0] left, left_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            left  <= '0;
        end else begin
            state <= state_n;
            left  <= left_n;
        end
    end

    always_comb begin
        state_n = state;
        left_n  = left;
        unique case (state)
            ST_IDLE: begin
                if (delay != '0) begin
                    state_n = ST_HOLD;
                    left_n  = delay;
                end
            end
            ST_HOLD: begin
                if (left == STALL_W'(1)) begin
                    state_n = ST_IDLE;
                    left_n  = '0;
                end else begin
                    left_n = left - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        stall_len = '0;
        cpu_wait  = 1'b0;
        unique case (state)
            ST_IDLE: stall_len = delay;
            ST_HOLD: cpu_wait  = 1'b1;
        endcase
    end
endmodule

// File: rtl/fzt_frame_timer.sv
module fzt_frame_timer
    import fzt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_io,
    input  logic [15:0]        req_addr,
    output logic               frame_irq,
    output logic [LINE_W-1:0]  line_num,
    output logic [POS_W-1:0]   line_pos,
    output logic               disp_active,
    output logic [STALL_W-1:0] stall_len,
    output logic               cpu_wait
);
    logic [STALL_W-1:0] delay;

    fzt_beam #(
        .LINE_T(LINE_T), .FRAME_LINES(FRAME_LINES), .IRQ_T(IRQ_T),
        .POS_W(POS_W), .LINE_W(LINE_W)
    ) u_beam (
        .clk(clk), .rst_n(rst_n),
        .pos(line_pos), .line(line_num), .irq(frame_irq)
    );

    fzt_contend #(
        .LINE_T(LINE_T), .DISP_T(DISP_T), .DISP_LINES(DISP_LINES),
        .TOP_LINES(TOP_LINES), .PHASES(PHASES), .MAX_STALL(MAX_STALL),
        .POS_W(POS_W), .LINE_W(LINE_W), .STALL_W(STALL_W), .PH_W(PH_W)
    ) u_cont (
        .pos(line_pos), .line(line_num),
        .req_valid(req_valid), .req_io(req_io), .req_addr(req_addr),
        .disp_active(disp_active), .delay(delay)
    );

    fzt_wait_fsm #(.STALL_W(STALL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .delay(delay),
        .stall_len(stall_len), .cpu_wait(cpu_wait)
    );
endmodule

// File: rtl/fzt_frame_chk.sv
module fzt_frame_chk
    import fzt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               frame_irq,
    input logic [LINE_W-1:0]  line_num,
    input logic [POS_W-1:0]   line_pos,
    input logic               disp_active,
    input logic [STALL_W-1:0] stall_len,
    input logic               cpu_wait
);
    localparam logic [POS_W-1:0]   P_LAST  = POS_W'(LINE_T - 1);
    localparam logic [POS_W-1:0]   P_DISP  = POS_W'(DISP_T);
    localparam logic [POS_W-1:0]   P_IRQ   = POS_W'(IRQ_T);
    localparam logic [LINE_W-1:0]  L_LAST  = LINE_W'(FRAME_LINES - 1);
    localparam logic [LINE_W-1:0]  L_FIRST = LINE_W'(TOP_LINES);
    localparam logic [LINE_W-1:0]  L_END   = LINE_W'(TOP_LINES + DISP_LINES);
    localparam logic [STALL_W-1:0] S_MAX   = STALL_W'(MAX_STALL);

    a_r1_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pos == P_LAST) |=> (line_pos == '0));
    a_r1_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pos == P_LAST && line_num != L_LAST) |=> (line_num == $past(line_num) + 1'b1));
    a_r2_irq_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_irq) |-> (line_num == '0 && line_pos == P_IRQ));
    a_r3_disp_area: assert property (@(posedge clk) disable iff (!rst_n)
        disp_active |-> (line_pos < P_DISP && line_num >= L_FIRST && line_num < L_END));
    a_r5_stall_max: assert property (@(posedge clk) disable iff (!rst_n)
        stall_len <= S_MAX);
    a_r5_border_free: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pos >= P_DISP && line_pos < P_LAST) |-> (stall_len == '0));
    a_r6_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (stall_len == '0));
    a_r7_wait_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_wait) |-> ($past(stall_len) != '0));
    a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> (stall_len == '0));
endmodule

bind fzt_frame_timer fzt_frame_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .frame_irq(frame_irq),
    .line_num(line_num), .line_pos(line_pos), .disp_active(disp_active),
    .stall_len(stall_len), .cpu_wait(cpu_wait)
);

// File: tb/sim_fzt_frame_timer.sv
module sim_fzt_frame_timer;
    localparam int FRAME = 69888;
    localparam int NV    = 14;
    // {frame cycle, io, addr, expected stall}
    localparam int VEC [NV][4] = '{
        '{100,   0, 16'h4000, 0},   // R5 top border
        '{14320, 0, 16'h4000, 0},   // R5 before window
        '{14335, 0, 16'h5000, 6},   // R5 first window cycle
        '{14345, 0, 16'h7FFF, 4},   // R5 phase 2
        '{14360, 1, 16'h00FE, 5},   // R4 even io, phase 1
        '{14370, 0, 16'h8000, 0},   // R4 uncontended mem
        '{14380, 1, 16'h00FF, 0},   // R4 odd io
        '{14390, 0, 16'h4000, 0},   // R5 phase 7
        '{14401, 0, 16'h4000, 4},   // R5 phase 2 later
        '{14455, 0, 16'h4000, 6},   // R5 phase 0 late in line
        '{14470, 0, 16'h4000, 0},   // R5 right border
        '{14559, 1, 16'hFFFE, 6},   // R4 even io, next line
        '{57130, 0, 16'h6000, 3},   // R5 last display line
        '{57343, 0, 16'h4000, 0}    // R5 bottom border
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_io = 1'b0;
    logic [15:0] req_addr = '0;
    logic        frame_irq, disp_active, cpu_wait;
    logic [8:0]  line_num;
    logic [7:0]  line_pos;
    logic [2:0]  stall_len;

    int tests = 0;
    int fails = 0;
    int cur = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fzt_frame_timer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io),
        .req_addr(req_addr), .frame_irq(frame_irq), .line_num(line_num),
        .line_pos(line_pos), .disp_active(disp_active),
        .stall_len(stall_len), .cpu_wait(cpu_wait)
    );

    task automatic check(input string rq, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", rq, cur, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        cur = (cur + 1) % FRAME;
        @(negedge clk);
    endtask

    task automatic goto(input int t);
        while (cur != t) tick();
    endtask

    task automatic count_wait(output int n, input int span);
        n = 0;
        for (int i = 0; i < span; i++) begin
            if (cpu_wait) n++;
            tick();
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 R2 R3 R7 reset state
        check("R1 reset pos", int'(line_pos), 0);
        check("R1 reset line", int'(line_num), 0);
        check("R2 reset irq", int'(frame_irq), 1);
        check("R7 reset wait", int'(cpu_wait), 0);
        rst_n = 1'b1;
        cur = 0;

        for (int v = 0; v < NV; v++) begin
            goto(VEC[v][0]);
            req_valid = 1'b1;
            req_io    = VEC[v][1][0];
            req_addr  = VEC[v][2][15:0];
            #1;
            check("R5 R6 stall_len", int'(stall_len), VEC[v][3]);
            tick();
            req_valid = 1'b0;
            count_wait(n, 8);
            check("R7 wait length", n, VEC[v][3]);
        end

        // R1 position and line at the window edges
        goto(14335);
        check("R1 line at 14335", int'(line_num), 63);
        check("R1 pos at 14335", int'(line_pos), 223);
        check("R3 disp before", int'(disp_active), 0);
        tick();
        check("R1 line at 14336", int'(line_num), 64);
        check("R3 disp first", int'(disp_active), 1);
        goto(14463);
        check("R3 disp pos127", int'(disp_active), 1);
        tick();
        check("R3 disp pos128", int'(disp_active), 0);

        // R8 request held high during the wait
        goto(14783);
        req_valid = 1'b1;
        req_io    = 1'b0;
        req_addr  = 16'h4100;
        #1;
        check("R8 first stall", int'(stall_len), 6);
        tick();
        #1;
        check("R8 held request stall", int'(stall_len), 0);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (cpu_wait) n++;
            if (i == 3) req_valid = 1'b0;
            tick();
        end
        check("R8 wait not extended", n + 0, 6);

        // R1 R2 frame wrap and interrupt end
        goto(FRAME - 1);
        check("R1 last line", int'(line_num), 311);
        check("R1 last pos", int'(line_pos), 223);
        check("R2 irq off at end", int'(frame_irq), 0);
        tick();
        check("R1 wrap line", int'(line_num), 0);
        check("R2 irq at 0", int'(frame_irq), 1);
        goto(31);
        check("R2 irq at 31", int'(frame_irq), 1);
        tick();
        check("R2 irq at 32", int'(frame_irq), 0);

        // R9 reset in the middle of a stall
        goto(14335);
        req_valid = 1'b1;
        req_addr  = 16'h4000;
        tick();
        req_valid = 1'b0;
        tick();
        check("R9 wait before reset", int'(cpu_wait), 1);
        rst_n = 1'b0;
        #1;
        check("R9 wait cleared", int'(cpu_wait), 0);
        check("R9 line cleared", int'(line_num), 0);
        check("R9 pos cleared", int'(line_pos), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cur = 0;
        tick();
        check("R9 restart pos", int'(line_pos), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule